// File: doc/BRIEF.md
# Frame score normaliser with shared model-entry cost

This block sits behind the state-score recursion of a log-domain Viterbi decoder. The unscaled cost of every state of every model arrives as a stream, one state per valid cycle, between a frame-start pulse and a frame-end pulse. Each incoming cost is rebased by subtracting the smallest cost of the previously completed frame. The rebased value is clamped into a narrow word, and any value that no longer fits is marked impossible. While the frame streams past, the block also tracks this frame's smallest cost, the state that holds it, and the smallest cost among exit states.

When the frame-end pulse arrives, the block latches the index of the winning state, which is where backtracking starts. It also latches one entry cost that every model's first state uses in the next frame. This cost is the best exit cost on the same rebased scale, plus a fixed exit-transition cost. The tracked minimum becomes the rebasing reference for the following frame. Each frame therefore uses one register for the reference while a second register accumulates the next reference.

For the first frame there is no recursion result. With the inject input held high, a separate initial-score port replaces the unscaled cost, and the rebasing reference is taken as zero.

Top module: `score_norm_unit`

## Requirements
- R1: After reset, o_valid and o_done are 0, o_best_idx is 0 and o_entry_cost is all ones (impossible). The rebasing reference is 0.
- R2: One cycle after a valid input, o_valid is 1 and o_score equals the input cost minus the reference. The reference is the smallest cost of the most recently completed frame.
- R3: If the input cost is all ones, or the rebased difference is 65535 or more, o_score is 16'hFFFF (impossible).
- R4: If the input cost is below the reference, o_score is 0.
- R5: One cycle after frm_end, o_done pulses for exactly one cycle and o_best_idx holds the index of the frame's smallest cost. A sample presented in the frm_end cycle is counted, and on a tie the earlier sample wins.
- R6: frm_start restarts the tracking, so costs from earlier frames never decide o_best_idx, the next reference or the exit cost. A sample presented in the frm_start cycle belongs to the new frame.
- R7: At frame end, o_entry_cost is the smallest exit-flagged cost rebased as in R2 to R4, plus EXIT_COST (default 40), saturated at 16'hFFFF. If no exit-flagged sample occurs, or the rebased exit cost is impossible, o_entry_cost is 16'hFFFF.
- R8: While inj is 1, s_raw is ignored. The zero-extended s_init_score is used as the cost for scaling and tracking, and the reference is taken as 0. The minimum of such a frame becomes the next reference.
- R9: o_best_idx and o_entry_cost change only in the cycle after frm_end. The reference used for scaling also stays fixed within a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Pulse: first state of a frame |
| frm_end | input | 1 | Pulse: last state of a frame |
| inj | input | 1 | Inject initial scores for this frame (held for the frame) |
| s_valid | input | 1 | Input sample valid |
| s_raw | input | RAW_W (24) | Unscaled state cost |
| s_init_score | input | SC_W (16) | Initial-frame cost used while inj is 1 |
| s_idx | input | IDX_W (8) | Global state index of the sample |
| s_exit | input | 1 | Sample is a model's exit state |
| o_valid | output | 1 | Rebased score valid |
| o_score | output | SC_W (16) | Rebased, saturated score |
| o_done | output | 1 | Frame results updated |
| o_best_idx | output | IDX_W (8) | Index of the frame's smallest cost |
| o_entry_cost | output | SC_W (16) | Shared entry cost for the next frame |

## Verification
A wrong reference register does not show up in the frame where it goes wrong. It appears as an offset on every o_score of the next frame, one cycle after each sample. A minimum tracker that is not restarted, or that misses the last sample, shows up only at the next frm_end, as a wrong o_best_idx. An error in the exit tracker appears at that same point as a wrong o_entry_cost. The directed frames therefore chain together, and each frame checks the reference left by the frame before it.

// File: rtl/score_norm_unit.sv
module score_norm_unit #(
  parameter int RAW_W     = 24,
  parameter int SC_W      = 16,
  parameter int N_STATES  = 147,
  parameter int EXIT_COST = 40,
  localparam int IDX_W    = $clog2(N_STATES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic             inj,
  input  logic             s_valid,
  input  logic [RAW_W-1:0] s_raw,
  input  logic [SC_W-1:0]  s_init_score,
  input  logic [IDX_W-1:0] s_idx,
  input  logic             s_exit,
  output logic             o_valid,
  output logic [SC_W-1:0]  o_score,
  output logic             o_done,
  output logic [IDX_W-1:0] o_best_idx,
  output logic [SC_W-1:0]  o_entry_cost
);

  localparam logic [RAW_W-1:0] RAW_MAX = '1;
  localparam logic [SC_W-1:0]  SC_MAX  = '1;
  localparam logic [RAW_W:0]   SC_LIM  = {{(RAW_W+1-SC_W){1'b0}}, SC_MAX};

  logic [RAW_W-1:0] ref_q, min_q, exit_q;
  logic [IDX_W-1:0] idx_q;

  function automatic logic [SC_W-1:0] rebase(input logic [RAW_W-1:0] v,
                                              input logic [RAW_W-1:0] r);
    logic [RAW_W:0] d;
    d = {1'b0, v} - {1'b0, r};
    if (v == RAW_MAX)  return SC_MAX;
    if (d[RAW_W])      return '0;
    if (d >= SC_LIM)   return SC_MAX;
    return d[SC_W-1:0];
  endfunction

  logic [RAW_W-1:0] val, eff_ref, base_min, base_exit, nxt_min, nxt_exit;
  logic [IDX_W-1:0] base_idx, nxt_idx;
  logic             take_min, take_exit;
  logic [SC_W-1:0]  ex_sc, entry_nxt;
  logic [SC_W:0]    ex_sum;

  assign val       = inj ? {{(RAW_W-SC_W){1'b0}}, s_init_score} : s_raw;
  assign eff_ref   = inj ? '0 : ref_q;

  assign base_min  = frm_start ? RAW_MAX : min_q;
  assign base_exit = frm_start ? RAW_MAX : exit_q;
  assign base_idx  = frm_start ? '0 : idx_q;

  assign take_min  = s_valid && (val < base_min);
  assign take_exit = s_valid && s_exit && (val < base_exit);

  assign nxt_min   = take_min  ? val   : base_min;
  assign nxt_idx   = take_min  ? s_idx : base_idx;
  assign nxt_exit  = take_exit ? val   : base_exit;

  assign ex_sc     = rebase(nxt_exit, eff_ref);
  assign ex_sum    = {1'b0, ex_sc} + (SC_W+1)'(EXIT_COST);
  assign entry_nxt = (ex_sc == SC_MAX || ex_sum[SC_W]) ? SC_MAX : ex_sum[SC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q        <= '0;
      min_q        <= RAW_MAX;
      exit_q       <= RAW_MAX;
      idx_q        <= '0;
      o_valid      <= 1'b0;
      o_score      <= '0;
      o_done       <= 1'b0;
      o_best_idx   <= '0;
      o_entry_cost <= SC_MAX;
    end else begin
      o_valid <= s_valid;
      if (s_valid) o_score <= rebase(val, eff_ref);
      min_q  <= nxt_min;
      exit_q <= nxt_exit;
      idx_q  <= nxt_idx;
      o_done <= frm_end;
      if (frm_end) begin
        ref_q        <= nxt_min;
        o_best_idx   <= nxt_idx;
        o_entry_cost <= entry_nxt;
      end
    end
  end

endmodule

// File: rtl/score_norm_unit_chk.sv
module score_norm_unit_chk #(
  parameter int RAW_W     = 24,
  parameter int SC_W      = 16,
  parameter int IDX_W     = 8,
  parameter int EXIT_COST = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_end,
  input logic             inj,
  input logic             s_valid,
  input logic [RAW_W-1:0] s_raw,
  input logic [SC_W-1:0]  s_init_score,
  input logic             o_valid,
  input logic [SC_W-1:0]  o_score,
  input logic             o_done,
  input logic [IDX_W-1:0] o_best_idx,
  input logic [SC_W-1:0]  o_entry_cost
);

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |=> o_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> !o_valid);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !inj && s_raw == '1) |=> (o_score == '1));
  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |=> o_done);
  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_end |=> !o_done);
  p_entry_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    o_entry_cost >= SC_W'(EXIT_COST));
  p_inj_impossible_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && inj && s_init_score == '1) |=> (o_score == '1));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_end |=> ($stable(o_best_idx) && $stable(o_entry_cost)));

endmodule

bind score_norm_unit score_norm_unit_chk #(
  .RAW_W(RAW_W), .SC_W(SC_W), .IDX_W(IDX_W), .EXIT_COST(EXIT_COST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .inj(inj),
  .s_valid(s_valid), .s_raw(s_raw), .s_init_score(s_init_score),
  .o_valid(o_valid), .o_score(o_score), .o_done(o_done),
  .o_best_idx(o_best_idx), .o_entry_cost(o_entry_cost)
);

// File: tb/sim_score_norm_unit.sv
`timescale 1ns/1ps
module sim_score_norm_unit;
  logic        clk = 0, rst_n = 0;
  logic        frm_start = 0, frm_end = 0, inj = 0, s_valid = 0, s_exit = 0;
  logic [23:0] s_raw = 0;
  logic [15:0] s_init_score = 0;
  logic [7:0]  s_idx = 0;
  logic        o_valid, o_done;
  logic [15:0] o_score, o_entry_cost;
  logic [7:0]  o_best_idx;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  score_norm_unit u0 (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
    .inj(inj), .s_valid(s_valid), .s_raw(s_raw), .s_init_score(s_init_score),
    .s_idx(s_idx), .s_exit(s_exit), .o_valid(o_valid), .o_score(o_score),
    .o_done(o_done), .o_best_idx(o_best_idx), .o_entry_cost(o_entry_cost)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [23:0] raw, input logic [7:0] idx, input logic ex,
                      input logic fs, input logic fe, input logic [15:0] exp,
                      input string tag);
    s_valid = 1; s_raw = raw; s_init_score = raw[15:0]; s_idx = idx;
    s_exit = ex; frm_start = fs; frm_end = fe;
    @(negedge clk);
    chk({tag, " valid"}, 32'(o_valid), 1);
    chk({tag, " score"}, 32'(o_score), 32'(exp));
    chk({tag, " done"}, 32'(o_done), 32'(fe));
    s_valid = 0; s_exit = 0; frm_start = 0; frm_end = 0;
  endtask

  task automatic frame_out(input string tag, input logic [7:0] idx, input logic [15:0] cost);
    chk({tag, " best_idx"}, 32'(o_best_idx), 32'(idx));
    chk({tag, " entry_cost"}, 32'(o_entry_cost), 32'(cost));
  endtask

  task automatic t_reset;
    chk("R1 o_valid", 32'(o_valid), 0);
    chk("R1 o_done", 32'(o_done), 0);
    chk("R1 best_idx", 32'(o_best_idx), 0);
    chk("R1 entry_cost", 32'(o_entry_cost), 32'hFFFF);
  endtask

  task automatic t_first;
    push(500, 0, 0, 1, 0, 500, "R1 ref zero");
    push(300, 1, 1, 0, 0, 300, "R2 a");
    push(700, 2, 1, 0, 1, 700, "R2 b");
    frame_out("R5 R7 first", 1, 340);
    @(negedge clk);
    chk("R5 done one cycle", 32'(o_done), 0);
  endtask

  task automatic t_scale;
    push(450, 0, 0, 1, 0, 150, "R2 rebase");
    push(310, 5, 1, 0, 0, 10, "R2 rebase exit");
    push(290, 6, 0, 0, 0, 0, "R4 below ref");
    push(70300, 7, 0, 0, 0, 16'hFFFF, "R3 overflow");
    push(24'hFFFFFF, 8, 0, 0, 0, 16'hFFFF, "R3 impossible in");
    push(290, 9, 1, 0, 1, 0, "R4 last sample");
    frame_out("R5 tie earlier wins R7 below ref", 6, 40);
  endtask

  task automatic t_noexit;
    push(400, 3, 0, 1, 0, 110, "R2 ref 290");
    push(400, 4, 0, 0, 1, 110, "R2 ref 290 b");
    frame_out("R7 no exit", 3, 16'hFFFF);
  endtask

  task automatic t_restart;
    push(900, 8, 1, 1, 0, 500, "R6 start sample");
    push(1000, 2, 0, 0, 1, 600, "R6 end sample");
    frame_out("R6 restart", 8, 540);
  endtask

  task automatic t_sat_entry;
    push(66400, 1, 1, 1, 1, 65500, "R7 single sample");
    frame_out("R7 saturate", 1, 16'hFFFF);
  endtask

  task automatic t_inject;
    inj = 1;
    push(20, 0, 0, 1, 0, 20, "R8 inject");
    s_raw = 24'h123456;
    push(24'h00FFFF, 1, 1, 0, 0, 16'hFFFF, "R8 inject impossible");
    push(24'h000005, 2, 1, 0, 1, 5, "R8 inject end");
    frame_out("R8 inject frame", 2, 45);
    inj = 0;
    push(25, 0, 0, 1, 1, 20, "R8 next ref");
    frame_out("R8 next frame", 0, 16'hFFFF);
  endtask

  task automatic t_hold;
    push(3, 4, 1, 1, 0, 0, "R9 mid frame");
    frame_out("R9 hold", 0, 16'hFFFF);
    chk("R9 no done", 32'(o_done), 0);
    @(negedge clk);
    chk("R9 idle valid", 32'(o_valid), 0);
    frame_out("R9 hold idle", 0, 16'hFFFF);
    push(100, 5, 0, 0, 1, 75, "R9 end");
    frame_out("R9 update", 4, 40);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_reset;
    t_first;
    t_scale;
    t_noexit;
    t_restart;
    t_sat_entry;
    t_inject;
    t_hold;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule